// File: doc/BRIEF.md
# Serial Charge-Halving DAC Sequencer

This block is the digital controller for a two-capacitor serial DAC that converts by repeated charge halving. A parallel code is captured when a start strobe is accepted. The output capacitor is first cleared. The code is then walked one bit at a time, starting with bit 0. For each bit there are two steps:

- **Load step:** the transfer capacitor is charged to the reference if the bit is 1, or drained to ground if the bit is 0.
- **Share step:** the two capacitors are tied together, which halves the charge between them.

After the final bit, the analog hold stage is put into track for a sampling window and is then switched back to hold. At that point the result is frozen and a new conversion may begin.

Every switch phase lasts `QUANTUM` clocks. Between any two phases there is always one clock with every switch open, so that conflicting switches are never closed together. The capacitors, the switches, the reference and the hold stage lie outside the block. The block only drives their control levels.

Top module: `scdac_seq`

## Requirements
- R1: A synchronous reset opens all four switches, drives `hold_o` low (track), clears `done_o` and `busy_o`, and returns the sequencer to idle, including when the reset arrives mid-conversion.
- R2: A start request seen while not busy captures `code_i`. In the clock that follows, `busy_o` is high and `clr_sw_o` is closed for `QUANTUM` clocks, before any bit is handled.
- R3: Bits are handled from bit 0 upward. In a bit's load phase, `chg_sw_o` is closed for `QUANTUM` clocks if the bit is 1, and `dis_sw_o` is closed instead if the bit is 0.
- R4: Each load phase is followed by a share phase of `QUANTUM` clocks in which `shr_sw_o` is the only closed switch.
- R5: At most one switch is closed in any clock. Every switch phase is separated from the next phase by exactly one clock with all switches open.
- R6: After `CODE_W` share phases and one open clock, `hold_o` is low (track) for a sampling window of `QUANTUM` clocks with all switches open. `hold_o` then rises.
- R7: `done_o` is a one-clock pulse in the clock where `hold_o` rises, and `busy_o` is low in that same clock. Counting the accepting edge as clock 0, this clock is `2*QUANTUM + 1 + CODE_W*(2*QUANTUM+2)`.
- R8: While busy, a start request is ignored. Changes on `code_i` after capture do not alter the switch pattern.
- R9: `hold_o` stays high from the end of a conversion until the sampling window of the next conversion. A start presented in the `done_o` clock is accepted at once.
- R10: When the switch pattern is applied to ideal equal capacitors, the held value equals the captured code divided by 2^`CODE_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request |
| code_i | input | CODE_W | Code to convert, captured on an accepted start |
| chg_sw_o | output | 1 | Close switch that charges the transfer capacitor to the reference |
| dis_sw_o | output | 1 | Close switch that drains the transfer capacitor |
| shr_sw_o | output | 1 | Close switch that ties the two capacitors together |
| clr_sw_o | output | 1 | Close switch that clears the output capacitor |
| hold_o | output | 1 | Hold stage control: 1 = hold, 0 = track |
| done_o | output | 1 | One-clock pulse when the result is held |
| busy_o | output | 1 | Conversion in progress |

## Verification
A corrupted shift register or bit counter shows up first as the wrong choice between charge and drain in a load phase. It also leaves a wrong number of share phases, so the sampling window and `done_o` move away from the expected clock. The bench catches both: it compares every output in every clock of a conversion, and it rebuilds the held value from the observed switch pattern. A phase timer or gap fault is visible within one quantum as two adjacent closed phases or as shortened dwell times.

// File: rtl/scdac_pkg.sv
package scdac_pkg;

   // Sequencer phases; GAP is the all-open clock between switch phases
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_CLR    = 3'd1,
      ST_GAP    = 3'd2,
      ST_LOAD   = 3'd3,
      ST_SHARE  = 3'd4,
      ST_SAMPLE = 3'd5,
      ST_HOLD   = 3'd6
   } seq_st_t;

endpackage

// File: rtl/scdac_phase_timer.sv
module scdac_phase_timer #(
   parameter int QUANTUM = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic run_i,
   output logic last_o
);
   localparam int CNT_W = (QUANTUM > 1) ? $clog2(QUANTUM) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(QUANTUM - 1);

   logic [CNT_W-1:0] cnt_q;

   // Final clock of a timed phase
   assign last_o = run_i && (cnt_q == LAST_CNT);

   always_ff @(posedge clk_i) begin
      if (rst_i || !run_i || last_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/scdac_bit_shifter.sv
module scdac_bit_shifter #(
   parameter int CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              adv_i,
   output logic              cur_bit_o,
   output logic              last_bit_o
);
   localparam int CNT_W = $clog2(CODE_W);
   localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(CODE_W - 1);

   logic [CODE_W-1:0] sh_q;
   logic [CNT_W-1:0]  idx_q;

   assign cur_bit_o  = sh_q[0];
   assign last_bit_o = (idx_q == TOP_IDX);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= code_i;
         idx_q <= '0;
      end else if (adv_i) begin
         sh_q  <= sh_q >> 1;
         idx_q <= last_bit_o ? '0 : idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/scdac_seq.sv
module scdac_seq
   import scdac_pkg::*;
#(
   parameter int CODE_W  = 8,
   parameter int QUANTUM = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              chg_sw_o,
   output logic              dis_sw_o,
   output logic              shr_sw_o,
   output logic              clr_sw_o,
   output logic              hold_o,
   output logic              done_o,
   output logic              busy_o
);
   // Elaboration-time parameter checks
   generate
      if (CODE_W < 4 || CODE_W > 16) begin : g_bad_code_w
         $error("scdac_seq: CODE_W must lie in 4..16");
      end
      if (QUANTUM < 1) begin : g_bad_quantum
         $error("scdac_seq: QUANTUM must be at least 1");
      end
   endgenerate

   seq_st_t state_q, state_d;
   seq_st_t after_q, after_d;
   logic    hold_q, hold_d;
   logic    timed, ph_last, accept, adv, cur_bit, bit_last;

   assign timed  = (state_q == ST_CLR) || (state_q == ST_LOAD) ||
                   (state_q == ST_SHARE) || (state_q == ST_SAMPLE);
   assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_HOLD));
   assign adv    = (state_q == ST_SHARE) && ph_last;

   scdac_phase_timer #(.QUANTUM(QUANTUM)) u_timer (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .run_i  (timed),
      .last_o (ph_last)
   );

   scdac_bit_shifter #(.CODE_W(CODE_W)) u_shift (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (accept),
      .code_i     (code_i),
      .adv_i      (adv),
      .cur_bit_o  (cur_bit),
      .last_bit_o (bit_last)
   );

   always_comb begin
      state_d = state_q;
      after_d = after_q;
      hold_d  = hold_q;
      unique case (state_q)
         ST_IDLE, ST_HOLD: state_d = accept ? ST_CLR : ST_IDLE;
         ST_CLR: begin
            if (ph_last) begin
               state_d = ST_GAP;
               after_d = ST_LOAD;
            end
         end
         ST_GAP: begin
            state_d = after_q;
            if (after_q == ST_SAMPLE) hold_d = 1'b0;
         end
         ST_LOAD: begin
            if (ph_last) begin
               state_d = ST_GAP;
               after_d = ST_SHARE;
            end
         end
         ST_SHARE: begin
            if (ph_last) begin
               state_d = ST_GAP;
               after_d = bit_last ? ST_SAMPLE : ST_LOAD;
            end
         end
         ST_SAMPLE: begin
            if (ph_last) begin
               state_d = ST_HOLD;
               hold_d  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_IDLE;
         after_q <= ST_IDLE;
         hold_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         after_q <= after_d;
         hold_q  <= hold_d;
      end
   end

   // Switch controls decoded from registered state only
   assign clr_sw_o = (state_q == ST_CLR);
   assign chg_sw_o = (state_q == ST_LOAD) && cur_bit;
   assign dis_sw_o = (state_q == ST_LOAD) && !cur_bit;
   assign shr_sw_o = (state_q == ST_SHARE);
   assign hold_o   = hold_q;
   assign done_o   = (state_q == ST_HOLD);
   assign busy_o   = (state_q != ST_IDLE) && (state_q != ST_HOLD);
endmodule

// File: rtl/scdac_seq_chk.sv
module scdac_seq_chk (
   input logic clk,
   input logic rst,
   input logic chg,
   input logic dis,
   input logic shr,
   input logic clr,
   input logic hold,
   input logic done,
   input logic busy
);
   logic [3:0] sw;
   assign sw = {clr, chg, dis, shr};

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (sw == 4'b0) && !hold && !done && !busy);

   // R5
   sw_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sw));

   // R5
   sw_gap_chk: assert property (@(posedge clk) disable iff (rst)
      ((|sw) && (|$past(sw))) |-> (sw == $past(sw)));

   // R7
   done_state_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (hold && !busy));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R7
   busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done);

   // R6
   hold_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hold) |-> done);
endmodule

bind scdac_seq scdac_seq_chk u_chk (
   .clk  (clk_i),
   .rst  (rst_i),
   .chg  (chg_sw_o),
   .dis  (dis_sw_o),
   .shr  (shr_sw_o),
   .clr  (clr_sw_o),
   .hold (hold_o),
   .done (done_o),
   .busy (busy_o)
);

// File: tb/scdac_seq_bench.sv
module scdac_seq_bench;
   localparam int W = 8;
   localparam int Q = 2;
   localparam int PER_BIT = 2 * Q + 2;
   localparam int SAMPLE_AT = Q + 1 + W * PER_BIT;
   localparam int T = SAMPLE_AT + Q;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [W-1:0] code_in = '0;
   logic chg, dis, shr, clr, hold, done, busy;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   logic prev_hold = 1'b0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   scdac_seq #(.CODE_W(W), .QUANTUM(Q)) u_scdac_seq (
      .clk_i(clk), .rst_i(rst), .start_i(start), .code_i(code_in),
      .chg_sw_o(chg), .dis_sw_o(dis), .shr_sw_o(shr), .clr_sw_o(clr),
      .hold_o(hold), .done_o(done), .busy_o(busy)
   );

   task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {clr,chg,dis,shr,hold,done,busy} actual=%b expected=%b",
                  tag, act, exp);
      end
   endtask

   // Expected outputs in clock k after the accepting edge
   function automatic logic [6:0] exp_vec(input int k, input logic [W-1:0] code,
                                          input logic hp);
      logic c = 0, ch = 0, d = 0, s = 0, h = hp, dn = 0, b = 1;
      if (k < Q) c = 1;
      else if (k == Q) c = 0;
      else if (k < SAMPLE_AT) begin
         int j = k - (Q + 1);
         int bi = j / PER_BIT;
         int r = j % PER_BIT;
         if (r < Q) begin ch = code[bi]; d = !code[bi]; end
         else if (r > Q && r < 2 * Q + 1) s = 1;
      end else if (k < T) h = 0;
      else begin h = 1; dn = 1; b = 0; end
      return {c, ch, d, s, h, dn, b};
   endfunction

   function automatic string tag_of(input int k);
      if (k < Q) return "R2";
      if (k == Q) return "R5";
      if (k < SAMPLE_AT) begin
         int r = (k - (Q + 1)) % PER_BIT;
         if (r < Q) return "R3";
         if (r == Q || r == 2 * Q + 1) return "R5";
         return "R4";
      end
      if (k < T) return "R6";
      return "R7";
   endfunction

   task automatic run_conv(input logic [W-1:0] code, input bit inject,
                           input bit predriven, input bit chain,
                           input logic [W-1:0] next_code);
      int inj_k = inject ? int'($urandom % (T - 1)) : -1;
      longint v2 = 0, c1 = 0;
      bit prev_s = 0;
      logic [6:0] act;
      if (!predriven) begin
         @(negedge clk);
         start = 1'b1;
         code_in = code;
      end
      @(posedge clk);
      for (int k = 0; k <= T; k++) begin
         @(negedge clk);
         act = {clr, chg, dis, shr, hold, done, busy};
         check((k == inj_k + 1 && inject) ? "R8" : tag_of(k), act, exp_vec(k, code, prev_hold));
         if (clr) v2 = 0;
         if (chg) c1 = longint'(1) << W;
         if (dis) c1 = 0;
         if (shr && !prev_s) v2 = (v2 + c1) / 2;
         prev_s = shr;
         start = 1'b0;
         code_in = W'($urandom);
         if (k == inj_k) start = 1'b1;
         if (k == T && chain) begin
            start = 1'b1;
            code_in = next_code;
         end
      end
      // R10: reconstructed held value from switch pattern
      check("R10", 7'(v2 == longint'(code)), 7'd1);
      prev_hold = 1'b1;
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1", {clr, chg, dis, shr, hold, done, busy}, 7'b0);

      // Directed corner codes
      run_conv('0, 0, 0, 0, '0);
      run_conv('1, 0, 0, 0, '0);
      run_conv(W'(1), 0, 0, 0, '0);
      run_conv(W'(1) << (W - 1), 0, 0, 0, '0);
      run_conv({(W/2){2'b01}}, 0, 0, 0, '0);
      @(negedge clk);
      // R9: hold persists while idle
      check("R9", {clr, chg, dis, shr, hold, done, busy}, 7'b0000100);

      // R9: back-to-back start in the done clock
      run_conv(W'(8'hA5), 0, 0, 1, W'(8'h3C));
      run_conv(W'(8'h3C), 0, 1, 0, '0);

      // Random conversions with ignored starts while busy
      for (int i = 0; i < 30; i++) begin
         run_conv(W'($urandom), (i % 2) == 0, 0, 0, '0);
      end

      // R1: reset in the middle of a conversion
      @(negedge clk);
      start = 1'b1;
      code_in = W'(8'hF0);
      @(negedge clk);
      start = 1'b0;
      repeat (12) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", {clr, chg, dis, shr, hold, done, busy}, 7'b0);
      rst = 1'b0;
      prev_hold = 1'b0;
      @(negedge clk);
      check("R1", {clr, chg, dis, shr, hold, done, busy}, 7'b0);
      run_conv(W'(8'h81), 1, 0, 0, '0);

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule